// File: doc/BRIEF.md
# Software-Generated Interrupt Dispatcher

This block takes one 64-bit request word for a software-generated interrupt, together with the index of the CPU that wrote it. It then decides which CPUs receive the interrupt and, for each one it selects, raises a pending-set strobe that names the CPU and the 4-bit interrupt number. A neighbouring pending store consumes that strobe. When the scan is over, a one-cycle kick pulse tells the wake-up logic that state changed, but only if at least one CPU was flagged.

The block supports two routing modes. In targeted mode a CPU is chosen when its affinity levels 1 to 3 match the request exactly and the bit at its level-0 affinity is set in a 16-bit target list. In broadcast mode every CPU except the requester is chosen. The block does not keep track of which CPU sent the interrupt. CPUs are visited one per cycle in ascending index order against a read-only affinity table. The handshake stays busy until the visit is complete, and a targeted scan stops as soon as its working target list runs empty.

Top module: `sgi_dispatch`

## Requirements
- R1: After reset, `req_ready` is 1 and both `pend_set` and `kick` are 0.
- R2: The request word fields are: target list in bits 15:0, affinity level 1 in bits 23:16, interrupt number in bits 27:24, affinity level 2 in bits 39:32, routing-mode bit at bit 40, and affinity level 3 in bits 55:48. Setting any other bit changes nothing at the outputs.
- R3: With bit 40 set (broadcast), every CPU except `req_cpu` is flagged exactly once, and the target list has no effect.
- R4: With bit 40 clear (targeted), a CPU is flagged only if its table bytes 31:8 (levels 3, 2, 1) equal the request's levels and the target-list bit indexed by its level-0 byte (table bits 7:0) is set.
- R5: In targeted mode a CPU whose level-0 affinity is 16 or more is never flagged.
- R6: Each targeted match clears that level-0 bit from a working copy of the list. A later CPU that has the same affinity is therefore not flagged.
- R7: A scan visits CPU 0 upward, one CPU per cycle. Each `pend_set` cycle carries the visited CPU on `pend_cpu` and the request's interrupt number on `pend_intid`.
- R8: A targeted scan ends in the cycle in which the working list becomes zero, and a request with an empty list takes one cycle. Broadcast scans and unfinished targeted scans take NUM_CPUS cycles.
- R9: `kick` is a one-cycle pulse in the first cycle after the scan ends, raised only if some CPU was flagged.
- R10: `req_ready` is 0 for the whole scan, and `pend_set` is never 1 while `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Dispatcher idle and able to accept a request |
| req_word | input | 64 | Request word |
| req_cpu | input | IDX_W | Index of the requesting CPU |
| cpu_aff | input | 32*NUM_CPUS | Affinity table, 32 bits per CPU: {level3, level2, level1, level0} |
| pend_set | output | 1 | Set the pending bit for `pend_cpu` / `pend_intid` |
| pend_cpu | output | IDX_W | CPU whose pending bit is set |
| pend_intid | output | 4 | Interrupt number being set |
| kick | output | 1 | One-cycle notification after a scan that flagged at least one CPU |

## Verification
The bench builds the block with NUM_CPUS = 8. Its affinity table holds a duplicated affinity, a CPU with level-0 equal to 20, a CPU with a distinct level-1 value and a CPU with non-zero levels 2 and 3. With this table, one sweep over 32 target-list combinations exercises first-match-only behaviour, out-of-range level 0 and early stop. Broadcast requests are issued from every requester index. Several requests carry garbage in all unused bits. For each request the bench compares the flagged set, the interrupt number, the scan length in cycles and the kick against a model computed from the requirements.

// File: rtl/sgi_pkg.sv
package sgi_pkg;
  localparam int AFF_W   = 8;
  localparam int LIST_W  = 16;
  localparam int INTID_W = 4;
  localparam int ENTRY_W = 4 * AFF_W;

  typedef struct packed {
    logic [AFF_W-1:0]   lvl3;
    logic [AFF_W-1:0]   lvl2;
    logic [AFF_W-1:0]   lvl1;
    logic               bcast;
    logic [INTID_W-1:0] intid;
    logic [LIST_W-1:0]  tlist;
  } sgi_req_t;

  typedef enum logic {ST_IDLE = 1'b0, ST_SCAN = 1'b1} scan_state_e;
endpackage

// File: rtl/sgi_req_decode.sv
module sgi_req_decode
  import sgi_pkg::*;
(
  input  logic [63:0] word,
  output sgi_req_t    req
);
  logic unused_bits;

  assign req.tlist = word[15:0];
  assign req.lvl1  = word[23:16];
  assign req.intid = word[27:24];
  assign req.lvl2  = word[39:32];
  assign req.bcast = word[40];
  assign req.lvl3  = word[55:48];
  assign unused_bits = ^{word[63:56], word[47:41], word[31:28]};
endmodule

// File: rtl/sgi_cpu_match.sv
module sgi_cpu_match
  import sgi_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic                 bcast,
  input  logic [3*AFF_W-1:0]   req_hi,
  input  logic [LIST_W-1:0]    tlist,
  input  logic [ENTRY_W-1:0]   entry,
  input  logic [IDX_W-1:0]     cpu_idx,
  input  logic [IDX_W-1:0]     src_idx,
  output logic                 hit,
  output logic [LIST_W-1:0]    tlist_after
);
  localparam int SEL_W = $clog2(LIST_W);

  logic [AFF_W-1:0] lvl0;
  logic             in_range;
  logic             hi_equal;
  logic             listed;
  logic             hit_tgt;

  always_comb begin
    lvl0     = entry[AFF_W-1:0];
    in_range = (lvl0[AFF_W-1:SEL_W] == '0);
    hi_equal = (entry[ENTRY_W-1:AFF_W] == req_hi);
    listed   = tlist[lvl0[SEL_W-1:0]];
    hit_tgt  = in_range && hi_equal && listed;
    if (bcast) begin
      hit         = (cpu_idx != src_idx);
      tlist_after = tlist;
    end else begin
      hit         = hit_tgt;
      tlist_after = tlist;
      if (hit_tgt) tlist_after[lvl0[SEL_W-1:0]] = 1'b0;
    end
  end
endmodule

// File: rtl/sgi_dispatch.sv
module sgi_dispatch
  import sgi_pkg::*;
#(
  parameter int NUM_CPUS = 8,
  localparam int IDX_W   = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic [63:0]                 req_word,
  input  logic [IDX_W-1:0]            req_cpu,
  input  logic [ENTRY_W*NUM_CPUS-1:0] cpu_aff,
  output logic                        pend_set,
  output logic [IDX_W-1:0]            pend_cpu,
  output logic [INTID_W-1:0]          pend_intid,
  output logic                        kick
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_CPUS - 1);

  sgi_req_t            dec;
  scan_state_e         state_q, state_d;
  logic [IDX_W-1:0]    idx_q, idx_d, src_q, src_d;
  logic [INTID_W-1:0]  intid_q, intid_d;
  logic                bcast_q, bcast_d;
  logic [3*AFF_W-1:0]  hi_q, hi_d;
  logic [LIST_W-1:0]   list_q, list_d, list_after;
  logic                any_q, any_d, kick_q, kick_d;
  logic                load_en, step_en, hit, scan_end;
  logic [ENTRY_W-1:0]  aff_arr [NUM_CPUS];
  logic [ENTRY_W-1:0]  cur_aff;

  sgi_req_decode u_decode (.word(req_word), .req(dec));

  for (genvar g = 0; g < NUM_CPUS; g++) begin : g_tbl
    assign aff_arr[g] = cpu_aff[g*ENTRY_W +: ENTRY_W];
  end

  assign cur_aff = aff_arr[idx_q];

  sgi_cpu_match #(.IDX_W(IDX_W)) u_match (
    .bcast      (bcast_q),
    .req_hi     (hi_q),
    .tlist      (list_q),
    .entry      (cur_aff),
    .cpu_idx    (idx_q),
    .src_idx    (src_q),
    .hit        (hit),
    .tlist_after(list_after)
  );

  always_comb begin
    load_en  = (state_q == ST_IDLE) && req_valid;
    step_en  = (state_q == ST_SCAN);
    scan_end = step_en && ((!bcast_q && (list_after == '0)) || (idx_q == LAST_IDX));
    state_d  = state_q;
    idx_d    = idx_q;
    src_d    = src_q;
    intid_d  = intid_q;
    bcast_d  = bcast_q;
    hi_d     = hi_q;
    list_d   = list_q;
    any_d    = any_q;
    kick_d   = 1'b0;
    if (load_en) begin
      state_d = ST_SCAN;
      idx_d   = '0;
      src_d   = req_cpu;
      intid_d = dec.intid;
      bcast_d = dec.bcast;
      hi_d    = {dec.lvl3, dec.lvl2, dec.lvl1};
      list_d  = dec.tlist;
      any_d   = 1'b0;
    end else if (step_en) begin
      idx_d  = idx_q + 1'b1;
      list_d = list_after;
      any_d  = any_q | hit;
      kick_d = scan_end && (any_q | hit);
      if (scan_end) state_d = ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      src_q   <= '0;
      intid_q <= '0;
      bcast_q <= 1'b0;
      hi_q    <= '0;
      list_q  <= '0;
      any_q   <= 1'b0;
      kick_q  <= 1'b0;
    end else begin
      kick_q <= kick_d;
      if (load_en || step_en) begin
        state_q <= state_d;
        idx_q   <= idx_d;
        src_q   <= src_d;
        intid_q <= intid_d;
        bcast_q <= bcast_d;
        hi_q    <= hi_d;
        list_q  <= list_d;
        any_q   <= any_d;
      end
    end
  end

  assign req_ready  = (state_q == ST_IDLE);
  assign pend_set   = step_en && hit;
  assign pend_cpu   = idx_q;
  assign pend_intid = intid_q;
  assign kick       = kick_q;

  assert_no_set_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pend_set |-> !req_ready);
  assert_kick_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> !kick);
  assert_kick_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    kick |-> req_ready);
  assert_ascending_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_set && $past(pend_set)) |-> (pend_cpu == $past(pend_cpu) + 1'b1));
  assert_skip_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_set && bcast_q) |-> (pend_cpu != src_q));
  assert_list_shrinks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_set && !bcast_q) |-> ($countones(list_after) == $countones(list_q) - 1));
  assert_lvl0_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_set && !bcast_q) |-> (cur_aff[AFF_W-1:4] == '0));
  assert_early_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !bcast_q && idx_q != '0) |-> (list_q != '0));
endmodule

// File: tb/tb_sgi_dispatch.sv
module tb_sgi_dispatch;
  localparam int N = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid;
  logic          req_ready;
  logic [63:0]   req_word;
  logic [2:0]    req_cpu;
  logic [N*32-1:0] cpu_aff;
  logic          pend_set;
  logic [2:0]    pend_cpu;
  logic [3:0]    pend_intid;
  logic          kick;

  int errors = 0;
  int checks = 0;
  logic [31:0] aff_t [N];

  localparam logic [63:0] JUNK = 64'hFF00_FE00_F000_0000;

  always #2.5 clk = ~clk;

  sgi_dispatch #(.NUM_CPUS(N)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_word(req_word), .req_cpu(req_cpu), .cpu_aff(cpu_aff),
    .pend_set(pend_set), .pend_cpu(pend_cpu), .pend_intid(pend_intid), .kick(kick)
  );

  initial begin
    aff_t[0] = {8'd0, 8'd0, 8'd0, 8'd0};
    aff_t[1] = {8'd0, 8'd0, 8'd0, 8'd1};
    aff_t[2] = {8'd0, 8'd0, 8'd0, 8'd2};
    aff_t[3] = {8'd0, 8'd0, 8'd0, 8'd15};
    aff_t[4] = {8'd0, 8'd0, 8'd1, 8'd0};
    aff_t[5] = {8'd0, 8'd0, 8'd0, 8'd1};
    aff_t[6] = {8'd0, 8'd0, 8'd0, 8'd20};
    aff_t[7] = {8'd1, 8'd2, 8'd3, 8'd4};
  end

  for (genvar g = 0; g < N; g++) begin : g_aff
    assign cpu_aff[g*32 +: 32] = aff_t[g];
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_req(input logic [63:0] w, input logic [2:0] src, input string tag);
    logic        bc;
    logic [15:0] lst;
    logic [23:0] hi;
    logic [3:0]  iid;
    logic [7:0]  exp_mask, got_mask;
    int          exp_cyc, got_cyc, kicks, bad_iid;
    bit          h;
    bc = w[40]; lst = w[15:0]; iid = w[27:24];
    hi = {w[55:48], w[39:32], w[23:16]};
    exp_mask = '0; exp_cyc = N;
    for (int c = 0; c < N; c++) begin
      if (!bc && lst == 16'd0) begin exp_cyc = c + 1; break; end
      if (bc) h = (c != int'(src));
      else h = (aff_t[c][31:8] == hi) && (aff_t[c][7:0] < 8'd16) && lst[aff_t[c][3:0]];
      if (h) begin
        exp_mask[c] = 1'b1;
        if (!bc) lst[aff_t[c][3:0]] = 1'b0;
      end
      if (!bc && lst == 16'd0) begin exp_cyc = c + 1; break; end
    end
    @(negedge clk);
    req_word = w; req_cpu = src; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    got_mask = '0; got_cyc = 0; kicks = 0; bad_iid = 0;
    forever begin
      if (pend_set) begin
        got_mask[pend_cpu] = 1'b1;
        if (pend_intid != iid) bad_iid++;
      end
      if (kick) kicks++;
      if (req_ready) break;
      got_cyc++;
      @(negedge clk);
    end
    chk(got_mask == exp_mask, {tag, " flagged set (R3/R4/R5/R6)"}, got_mask, exp_mask);
    chk(bad_iid == 0, {tag, " interrupt number R7 R2"}, bad_iid, 0);
    chk(got_cyc == exp_cyc, {tag, " scan length R8 R10"}, got_cyc, exp_cyc);
    chk(kicks == (exp_mask != 0 ? 1 : 0), {tag, " kick R9"}, kicks, (exp_mask != 0 ? 1 : 0));
    @(negedge clk);
    chk(kick == 1'b0, {tag, " kick single pulse R9"}, kick, 0);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [63:0] w;
    logic [15:0] l;
    rst_n = 1'b0; req_valid = 1'b0; req_word = '0; req_cpu = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
    chk(pend_set == 1'b0, "R1 pend_set after reset", pend_set, 0);
    chk(kick == 1'b0, "R1 kick after reset", kick, 0);

    // R3: broadcast from every requester, list contents irrelevant
    for (int s = 0; s < N; s++) begin
      w = '0;
      w[40] = 1'b1;
      w[27:24] = 4'(s * 2 + 1);
      w[15:0] = (s % 2 == 0) ? 16'hFFFF : 16'h0000;
      run_req(w, 3'(s), "bcast");
    end
    run_req(64'h0000_0100_0A00_0000 | JUNK, 3'd5, "bcast junk R2");

    // R4 R5 R6 R8: targeted sweep, levels 3..1 all zero
    for (int m = 0; m < 32; m++) begin
      l = '0;
      l[0] = m[0]; l[1] = m[1]; l[2] = m[2]; l[15] = m[3]; l[5] = m[4];
      w = '0;
      w[15:0] = l;
      w[27:24] = 4'(m);
      run_req(w, 3'(m % N), "tgt sweep");
      if (m % 8 == 3) run_req(w | JUNK, 3'd0, "tgt sweep junk R2");
    end

    // R4: level-1 distinct CPU
    run_req(64'h0000_0000_0301_0001, 3'd0, "lvl1 bit0");
    run_req(64'h0000_0000_0301_0003, 3'd0, "lvl1 bits01");
    run_req(64'h0000_0000_0301_0000, 3'd0, "lvl1 empty list");
    // R4 R2: levels 3/2/1 all distinct
    run_req(64'h0001_0002_0C03_0010, 3'd2, "lvl321 hit");
    run_req(64'h0001_0000_0C03_0010, 3'd2, "lvl2 mismatch");
    run_req(64'h0000_0002_0C03_0010, 3'd2, "lvl3 mismatch");
    // R5: bit 4 set at level 0 everywhere: CPU with level-0 20 must not alias
    run_req(64'h0000_0000_0700_0010, 3'd1, "lvl0 20 R5");
    // R8: no CPU can ever match, full scan, no kick
    run_req(64'h0000_0000_0202_FFFF, 3'd1, "no match R9");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule